// File: doc/BRIEF.md
# Translation Fault Reporter

This block sits beside the page-table walker of a DMA address translation unit. It records the first translation fault the walker reports: a 3-bit fault class, the requester's bus number, its device/function number and the 32-bit device address that failed. It holds that record in one 64-bit status word until software acknowledges it. While the record is held and reporting is enabled, it drives a level interrupt. A small register port lets software read the status word and write acknowledge bits. The same port gives access to a control register that holds the global enable. It also serves three flush-all command registers, and each write to one of them fires a one-cycle strobe toward a translation cache: the device table cache, the page TLB or the page-walk cache.

Capture is run by a two-state machine. In `ST_IDLE` nothing is held. The *capture* transition (`ST_IDLE` to `ST_PENDING`) fires on a fault from the walker. The *acknowledge* transition (`ST_PENDING` to `ST_IDLE`) fires on a valid acknowledge write when no new fault arrives in the same cycle. The *refill* transition (`ST_PENDING` to `ST_PENDING` with new contents) fires when a valid acknowledge and a new fault coincide. A fault that arrives in `ST_PENDING` with no acknowledge leaves the record untouched and sets a sticky overflow flag instead.

Register offsets, in words on `reg_addr`: 0 is status, 1 is control, 2 is the device-table-cache flush, 3 is the page-TLB flush and 4 is the walk-cache flush. Offsets 5 to 7 are unused.

Top module: `xlate_fault_reporter`

## Requirements
- R1: After reset the status word reads 0, the control register reads 0, `irq` is low and all three flush strobes are low.
- R2: A fault on `flt_valid` while nothing is pending is visible in the status word from the next clock. Bit 63 is 1, the fault class is at 61:59, the bus number at 52:45, the device/function number at 44:37 and the device address at 31:0.
- R3: While a fault is pending, a further fault with no valid acknowledge in the same cycle leaves bits 61:59, 52:37 and 31:0 unchanged and sets the overflow flag at bit 58 from the next clock.
- R4: For a held fault of class 3, a status write with bit 63 set and bit 62 clear clears the whole status word, overflow included, on the next clock. A status write with both bits set is ignored.
- R5: For a held fault of any class other than 3, a status write with bits 63 and 62 both set clears the status word on the next clock. A write with bit 62 clear, or with bit 63 clear, is ignored.
- R6: `irq` is high exactly when a fault is pending and control bit 63 (enable) is 1. Faults are captured whatever the enable says.
- R7: Control bit 63 and the 12-bit field at bits 21:10 are writable and read back. All other control bits read 0.
- R8: A write to offset 2, 3 or 4, whatever its data, raises `flush_dev_tlb`, `flush_page_tlb` or `flush_walk_cache` respectively for exactly the one cycle after the write clock. No other write raises a strobe.
- R9: When a valid acknowledge and a new fault arrive in the same cycle, the new fault is captured with the overflow flag clear.
- R10: Bit 62 of the status word, the unused status bits 57:53 and 36:32, the flush offsets and the unused offsets 5 to 7 all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Walker reports a fault this cycle |
| flt_type | input | 3 | Fault class |
| flt_bus | input | 8 | Requester bus number |
| flt_devfn | input | 8 | Requester device/function number |
| flt_addr | input | 32 | Faulting device address |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| flush_dev_tlb | output | 1 | One-cycle device-table-cache flush strobe |
| flush_page_tlb | output | 1 | One-cycle page-TLB flush strobe |
| flush_walk_cache | output | 1 | One-cycle walk-cache flush strobe |

## Verification
A wrong state in the capture machine shows up at once on `irq` and on bit 63 of the status word, on the first clock after the fault or acknowledge. A held record that is corrupted by a later fault shows up as a changed class, requester or address field on the next status read. A wrong choice between the two acknowledge paths shows up either way: a word that stays pending after the correct write, or a word that clears after the write meant for the other class. The bench therefore sweeps every fault class through capture, an overflowing second fault, both wrong acknowledge patterns and the correct one, and reads the word back after each step. A flush decode fault shows up as a strobe on the wrong pin, or as a strobe that lasts more than one cycle, right after the write.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

    localparam int WORD_W      = 64;
    localparam int TYPE_W      = 3;
    localparam int BUS_W       = 8;
    localparam int DEVFN_W     = 8;
    localparam int DA_W        = 32;
    localparam int CTL_FLD_W   = 12;
    localparam int CTL_FLD_LSB = 10;

    // status word layout
    localparam int PEND_BIT    = 63;
    localparam int ACK_BIT     = 62;
    localparam int TYPE_LSB    = 59;
    localparam int OVF_BIT     = 58;
    localparam int BUS_LSB     = 45;
    localparam int DEVFN_LSB   = 37;
    localparam int DA_LSB      = 0;

    // control word layout
    localparam int ENABLE_BIT  = 63;

    // fault class acknowledged with the pending bit alone
    localparam logic [TYPE_W-1:0] TYPE_SELF_ACK = 3'd3;

    // register word offsets
    localparam int OFS_STATUS  = 0;
    localparam int OFS_CTRL    = 1;
    localparam int OFS_FLUSH0  = 2;
    localparam int NUM_FLUSH   = 3;

    typedef enum logic {
        ST_IDLE,
        ST_PENDING
    } fault_state_t;

    typedef struct packed {
        logic [TYPE_W-1:0]  ftype;
        logic [BUS_W-1:0]   bus;
        logic [DEVFN_W-1:0] devfn;
        logic [DA_W-1:0]    addr;
    } fault_rec_t;

endpackage

// File: rtl/xfr_capture.sv
module xfr_capture
    import xfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_valid,
    input  fault_rec_t flt_in,
    input  logic       stat_wr,
    input  logic       wr_pend_bit,
    input  logic       wr_ack_bit,
    output logic       pend,
    output logic       ovf,
    output logic       ack_ok,
    output fault_rec_t rec
);

    fault_state_t state_q;
    fault_state_t state_d;
    logic         load;
    logic         self_ack_class;

    assign pend           = (state_q == ST_PENDING);
    assign self_ack_class = (rec.ftype == TYPE_SELF_ACK);

    // acknowledge pattern depends on the held class
    assign ack_ok = stat_wr && pend && wr_pend_bit &&
                    (self_ack_class ? !wr_ack_bit : wr_ack_bit);

    assign load = flt_valid && ((state_q == ST_IDLE) || ack_ok);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flt_valid) state_d = ST_PENDING;        // capture
            end
            ST_PENDING: begin
                if (ack_ok && !flt_valid) state_d = ST_IDLE; // acknowledge
                // ack_ok && flt_valid: refill, stay pending
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // record and overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec <= '0;
            ovf <= 1'b0;
        end else if (load) begin
            rec <= flt_in;
            ovf <= 1'b0;
        end else if (ack_ok) begin
            rec <= '0;
            ovf <= 1'b0;
        end else if (pend && flt_valid) begin
            ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/xfr_regport.sv
module xfr_regport
    import xfr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic                 pend,
    input  logic                 ovf,
    input  fault_rec_t           rec,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 stat_wr,
    output logic                 ctl_en,
    output logic [NUM_FLUSH-1:0] flush_q
);

    logic                 ctl_wr;
    logic [CTL_FLD_W-1:0] ctl_fld_q;
    logic [WORD_W-1:0]    stat_word;
    logic [WORD_W-1:0]    ctl_word;

    assign stat_wr = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
    assign ctl_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_fld_q <= '0;
        end else if (ctl_wr) begin
            ctl_en    <= reg_wdata[ENABLE_BIT];
            ctl_fld_q <= reg_wdata[CTL_FLD_LSB +: CTL_FLD_W];
        end
    end

    // one registered strobe per flush offset
    for (genvar g = 0; g < NUM_FLUSH; g++) begin : g_flush
        logic strobe_q;
        always_ff @(posedge clk) begin
            if (!rst_n) strobe_q <= 1'b0;
            else        strobe_q <= reg_wr && (reg_addr == ADDR_W'(OFS_FLUSH0 + g));
        end
        assign flush_q[g] = strobe_q;
    end

    always_comb begin
        stat_word                           = '0;
        stat_word[PEND_BIT]                 = pend;
        stat_word[OVF_BIT]                  = ovf;
        stat_word[TYPE_LSB  +: TYPE_W]      = rec.ftype;
        stat_word[BUS_LSB   +: BUS_W]       = rec.bus;
        stat_word[DEVFN_LSB +: DEVFN_W]     = rec.devfn;
        stat_word[DA_LSB    +: DA_W]        = rec.addr;
    end

    always_comb begin
        ctl_word                            = '0;
        ctl_word[ENABLE_BIT]                = ctl_en;
        ctl_word[CTL_FLD_LSB +: CTL_FLD_W]  = ctl_fld_q;
    end

    always_comb begin
        if (reg_addr == ADDR_W'(OFS_STATUS))    reg_rdata = stat_word;
        else if (reg_addr == ADDR_W'(OFS_CTRL)) reg_rdata = ctl_word;
        else                                    reg_rdata = '0;
    end

endmodule

// File: rtl/xlate_fault_reporter.sv
module xlate_fault_reporter
    import xfr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flt_valid,
    input  logic [TYPE_W-1:0]   flt_type,
    input  logic [BUS_W-1:0]    flt_bus,
    input  logic [DEVFN_W-1:0]  flt_devfn,
    input  logic [DA_W-1:0]     flt_addr,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq,
    output logic                flush_dev_tlb,
    output logic                flush_page_tlb,
    output logic                flush_walk_cache
);

    fault_rec_t           flt_in;
    fault_rec_t           cap_rec;
    logic                 pend;
    logic                 ovf;
    logic                 ack_ok;
    logic                 stat_wr;
    logic                 ctl_en;
    logic [NUM_FLUSH-1:0] flush_q;

    assign flt_in = '{ftype: flt_type, bus: flt_bus, devfn: flt_devfn, addr: flt_addr};

    xfr_capture u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .flt_valid   (flt_valid),
        .flt_in      (flt_in),
        .stat_wr     (stat_wr),
        .wr_pend_bit (reg_wdata[PEND_BIT]),
        .wr_ack_bit  (reg_wdata[ACK_BIT]),
        .pend        (pend),
        .ovf         (ovf),
        .ack_ok      (ack_ok),
        .rec         (cap_rec)
    );

    xfr_regport #(.ADDR_W(ADDR_W)) u_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend      (pend),
        .ovf       (ovf),
        .rec       (cap_rec),
        .reg_rdata (reg_rdata),
        .stat_wr   (stat_wr),
        .ctl_en    (ctl_en),
        .flush_q   (flush_q)
    );

    assign irq              = pend & ctl_en;
    assign flush_dev_tlb    = flush_q[0];
    assign flush_page_tlb   = flush_q[1];
    assign flush_walk_cache = flush_q[2];

endmodule

// File: rtl/xfr_checker.sv
module xfr_checker
    import xfr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flt_valid,
    input logic                 pend,
    input logic                 ovf,
    input logic                 ack_ok,
    input fault_rec_t           rec,
    input logic                 irq,
    input logic                 ctl_en,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [NUM_FLUSH-1:0] flush_q
);

    // R2
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && flt_valid) |=> pend);

    // R3
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack_ok) |=> $stable(rec));

    assert_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && flt_valid && !ack_ok) |=> ovf);

    // R4 and R5: a valid acknowledge without a new fault empties the word
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && !flt_valid) |=> (!pend && !ovf));

    // R6
    assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !irq);

    // R8
    assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_q));

    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q[0] |-> $past(reg_wr && (reg_addr == ADDR_W'(OFS_FLUSH0))));

    // R9
    assert_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && flt_valid) |=> (pend && !ovf));

endmodule

bind xlate_fault_reporter xfr_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_valid (flt_valid),
    .pend      (pend),
    .ovf       (ovf),
    .ack_ok    (ack_ok),
    .rec       (cap_rec),
    .irq       (irq),
    .ctl_en    (ctl_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .flush_q   (flush_q)
);

// File: tb/xlate_fault_reporter_test.sv
`timescale 1ns/1ps
module xlate_fault_reporter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flt_valid;
    logic [2:0]  flt_type;
    logic [7:0]  flt_bus;
    logic [7:0]  flt_devfn;
    logic [31:0] flt_addr;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        irq;
    logic        flush_dev_tlb;
    logic        flush_page_tlb;
    logic        flush_walk_cache;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    xlate_fault_reporter uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .flt_valid        (flt_valid),
        .flt_type         (flt_type),
        .flt_bus          (flt_bus),
        .flt_devfn        (flt_devfn),
        .flt_addr         (flt_addr),
        .reg_wr           (reg_wr),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .irq              (irq),
        .flush_dev_tlb    (flush_dev_tlb),
        .flush_page_tlb   (flush_page_tlb),
        .flush_walk_cache (flush_walk_cache)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_fault(input logic [2:0] t, input logic [7:0] b,
                             input logic [7:0] df, input logic [31:0] ad);
        flt_valid = 1'b1; flt_type = t; flt_bus = b; flt_devfn = df; flt_addr = ad;
    endtask

    task automatic fault(input logic [2:0] t, input logic [7:0] b,
                         input logic [7:0] df, input logic [31:0] ad);
        set_fault(t, b, df, ad);
        step();
        flt_valid = 1'b0;
    endtask

    function automatic logic [63:0] status_of(input logic p, input logic [2:0] t, input logic o,
                                              input logic [7:0] b, input logic [7:0] df,
                                              input logic [31:0] ad);
        return {p, 1'b0, t, o, 5'b0, b, df, 5'b0, ad};
    endfunction

    function automatic logic [2:0] strobes();
        return {flush_walk_cache, flush_page_tlb, flush_dev_tlb};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv;
        logic [63:0] ctl_exp;
        rst_n = 1'b0; flt_valid = 1'b0; flt_type = '0; flt_bus = '0; flt_devfn = '0;
        flt_addr = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(3'd0, rv); check("R1 status", rv, 64'h0);
        rd(3'd1, rv); check("R1 control", rv, 64'h0);
        check("R1 irq", {63'b0, irq}, 64'h0);
        check("R1 strobes", {61'b0, strobes()}, 64'h0);

        // R7 control readback
        wr(3'd1, '1);
        ctl_exp = (64'h1 << 63) | (64'hFFF << 10);
        rd(3'd1, rv); check("R7 control all ones", rv, ctl_exp);
        check("R6 irq with nothing pending", {63'b0, irq}, 64'h0);
        wr(3'd1, 64'h100 << 10);
        rd(3'd1, rv); check("R7 control field only", rv, 64'h100 << 10);
        wr(3'd1, (64'h1 << 63) | (64'h100 << 10) | 64'h3FF);
        rd(3'd1, rv); check("R7 control enable", rv, (64'h1 << 63) | (64'h100 << 10));

        // sweep every fault class: capture, overflow, wrong acks, correct ack
        for (int t = 0; t < 8; t++) begin
            logic [7:0]  b;
            logic [7:0]  df;
            logic [31:0] ad;
            logic [63:0] exp_w;
            b  = 8'(t * 37 + 5);
            df = 8'(t * 19 + 1);
            ad = 32'hA5A5_0000 ^ 32'(t * 32'h0101_1111);
            fault(3'(t), b, df, ad);
            exp_w = status_of(1'b1, 3'(t), 1'b0, b, df, ad);
            rd(3'd0, rv); check("R2 capture fields", rv, exp_w);
            check("R6 irq while pending", {63'b0, irq}, 64'h1);

            fault(3'(t + 1), ~b, ~df, ~ad);
            exp_w = status_of(1'b1, 3'(t), 1'b1, b, df, ad);
            rd(3'd0, rv); check("R3 hold and overflow", rv, exp_w);

            // pattern meant for the other class path is ignored
            if (t == 3) begin
                wr(3'd0, 64'h3 << 62);
                rd(3'd0, rv); check("R4 both bits ignored for class 3", rv, exp_w);
            end else begin
                wr(3'd0, 64'h1 << 63);
                rd(3'd0, rv); check("R5 pending bit alone ignored", rv, exp_w);
            end
            wr(3'd0, 64'h1 << 62);
            rd(3'd0, rv); check("R5 write without pending bit ignored", rv, exp_w);

            if (t == 3) wr(3'd0, 64'h1 << 63);
            else        wr(3'd0, 64'h3 << 62);
            rd(3'd0, rv); check(t == 3 ? "R4 class 3 acknowledge" : "R5 acknowledge", rv, 64'h0);
            check("R6 irq after acknowledge", {63'b0, irq}, 64'h0);
        end

        // R6 capture while disabled, then enable
        wr(3'd1, 64'h0);
        fault(3'd2, 8'h12, 8'h34, 32'h0001_F000);
        rd(3'd0, rv);
        check("R6 captured while disabled", rv, status_of(1'b1, 3'd2, 1'b0, 8'h12, 8'h34, 32'h0001_F000));
        check("R6 irq masked", {63'b0, irq}, 64'h0);
        wr(3'd1, 64'h1 << 63);
        check("R6 irq after enable", {63'b0, irq}, 64'h1);

        // R9 acknowledge and new fault together
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 64'h3 << 62;
        set_fault(3'd5, 8'h9A, 8'hBC, 32'hDEAD_BEEF);
        step();
        reg_wr = 1'b0; reg_wdata = '0; flt_valid = 1'b0;
        rd(3'd0, rv);
        check("R9 refill", rv, status_of(1'b1, 3'd5, 1'b0, 8'h9A, 8'hBC, 32'hDEAD_BEEF));
        wr(3'd0, 64'h3 << 62);
        rd(3'd0, rv); check("R5 clear after refill", rv, 64'h0);

        // R8 flush strobes for each offset and several data patterns
        for (int o = 2; o < 5; o++) begin
            for (int p = 0; p < 3; p++) begin
                logic [63:0] d;
                d = (p == 0) ? 64'h0 : (p == 1) ? '1 : 64'h5555_AAAA_0F0F_F0F0;
                wr(3'(o), d);
                check("R8 strobe pulse", {61'b0, strobes()}, 64'(3'b001 << (o - 2)));
                step();
                check("R8 strobe one cycle", {61'b0, strobes()}, 64'h0);
            end
        end
        wr(3'd0, '1);
        check("R8 status write no strobe", {61'b0, strobes()}, 64'h0);
        wr(3'd1, 64'h1 << 63);
        check("R8 control write no strobe", {61'b0, strobes()}, 64'h0);

        // R10 unmapped and flush offsets read zero
        for (int o = 2; o < 8; o++) begin
            rd(3'(o), rv); check("R10 zero read", rv, 64'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule